// File: doc/BRIEF.md
# Thirty-Two Pin I/O Bank with Level and Edge Interrupts

This block is a bank of general-purpose pins behind a simple register bus. The bus has an address, a write strobe, write data and read data that the block returns in the same cycle. Software sets the value each pin drives and chooses whether the pin is driven or left as an input. It also sets, per pin, which of four conditions raise an interrupt: the pin held low, the pin held high, a rising change or a falling change. Each pin's incoming level passes through a two-flop synchronizer. Every event that is detected latches into a sticky status bit, which software clears by writing a one to it.

Two outputs are built from the status. The bank interrupt is the OR of status bits whose interrupt enable is set. The wake request is the OR of status bits whose wake enable is set, and it only asserts while a global wake switch in the configuration register is on. The data-out, interrupt-enable and wake-enable registers each have write-one set and write-one clear addresses. With these, a single bus write changes chosen bits without a read-modify-write.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is asserted and right after it, the interrupt enable, status, data-out, wake enable and all detect enables read 0. The direction register reads all ones, so no pin is driven. irq_out and wake_out are 0.
- R2: Address 0x00 reads the major revision in bits 7:4 and the minor revision in bits 3:0, which is 0x25 by default. Address 0x14 reads 1 in bit 0 once reset has finished. Address 0x30 holds a two-bit control value in bits 1:0 and reads it back.
- R3: The direction register is at 0x34. A one makes that pin an input, with pin_drive 0. A zero makes pin_drive 1. pin_out always carries the data-out register.
- R4: Data-out is at 0x3C. Writing 0x94 sets the data-out bits written as one, and writing 0x90 clears them. Bits written as zero keep their value.
- R5: The interrupt enable is at 0x1C and is written whole there. Writing 0x64 sets the written-one bits and writing 0x60 clears them. Reads of 0x60 and 0x64 return the enable.
- R6: Address 0x38 returns the pin levels after two synchronizer flops. A pin change made before clock edge k is visible after edge k+1 and not after edge k alone.
- R7: A rising change on a pin whose bit is set in 0x48, or a falling change on a pin whose bit is set in 0x4C, sets that pin's status bit. Status is at 0x18, and the bit sets at the third clock edge after the pin change. A pin that stays at its new level raises no further event.
- R8: Status sets while a pin is low with its bit set in 0x40, or high with its bit set in 0x44. When a clear and a detected event hit the same bit in one cycle, the set wins. A cleared bit whose level still holds therefore reads back as 1.
- R9: Writing a one to a status bit at 0x18 clears it, and writing a zero leaves it unchanged.
- R10: irq_out is a register loaded with the OR of status AND interrupt enable. It rises one cycle after the status bit and falls one cycle after the clear. A status bit whose enable is 0 does not raise it.
- R11: The wake enable is changed by writing ones to 0x84 (set) or 0x80 (clear), and reads back at either address. wake_out is a register loaded with the OR of status AND wake enable. It is held at 0 unless bit 2 of the configuration register at 0x10 is 1.
- R12: A pin with all four detect enables at 0 never sets its status bit, however it toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, same cycle |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value driven on each pin |
| pin_drive | output | 32 | 1 where the pin is driven from pin_out |
| irq_out | output | 1 | Bank interrupt request |
| wake_out | output | 1 | Wake request |

## Verification
The bench targets the cycle on which a pin change becomes visible, first in the data-in register and then in status and the interrupt. A synchronizer with the wrong depth or an unregistered interrupt moves those edges by a cycle and misses the sampled window. It clears a level-detected bit while the level still holds and expects it back, which catches a clear-wins priority. It also writes zeros to status, which catches a plain write that wipes every bit. It drives the set and clear aliases with mixed bit patterns, and it toggles pins whose detect enables are off, where a design that ignores the enables or the interrupt mask would show status or an interrupt. The global wake switch is tested with a pending wake source, so a wake output that skips the gate would rise early.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [7:0] {
    A_REV       = 8'h00,
    A_SYSCFG    = 8'h10,
    A_SYSSTAT   = 8'h14,
    A_STATUS    = 8'h18,
    A_IRQEN     = 8'h1C,
    A_CTRL      = 8'h30,
    A_DIR       = 8'h34,
    A_DIN       = 8'h38,
    A_DOUT      = 8'h3C,
    A_LOWDET    = 8'h40,
    A_HIGHDET   = 8'h44,
    A_RISEDET   = 8'h48,
    A_FALLDET   = 8'h4C,
    A_IRQEN_CLR = 8'h60,
    A_IRQEN_SET = 8'h64,
    A_WAKE_CLR  = 8'h80,
    A_WAKE_SET  = 8'h84,
    A_DOUT_CLR  = 8'h90,
    A_DOUT_SET  = 8'h94
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } upd_op_e;

  localparam int WAKE_GLB_BIT = 2;
  localparam int CTRL_W       = 2;

  // Decode one bus write into the update applied to an aliased register.
  function automatic upd_op_e pick_op(input logic we, input logic [7:0] a,
                                      input logic use_full, input logic [7:0] full_a,
                                      input logic [7:0] set_a, input logic [7:0] clr_a);
    upd_op_e op;
    op = OP_NONE;
    if (we) begin
      if (use_full && a == full_a) op = OP_WRITE;
      else if (a == set_a)         op = OP_SET;
      else if (a == clr_a)         op = OP_CLR;
    end
    return op;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  upd_op_e      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = (op != OP_NONE);
    unique case (op)
      OP_WRITE: d = wdata;
      OP_SET:   d = q | wdata;
      OP_CLR:   d = q & ~wdata;
      default:  d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] low_en,
  input  logic [W-1:0] high_en,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] status_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_ev, fall_ev;
    assign rise_ev = lvl[i] & ~prev_q[i];
    assign fall_ev = ~lvl[i] & prev_q[i];
    assign hit[i]  = (low_en[i] & ~lvl[i]) | (high_en[i] & lvl[i]) |
                     (rise_en[i] & rise_ev) | (fall_en[i] & fall_ev);
  end

  // A new event outranks a clear aimed at the same bit.
  always_comb begin
    status_d = status;
    if (clr_we) status_d = status_d & ~clr_mask;
    status_d = status_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= lvl;
      status <= status_d;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_drive,
  output logic              irq_out,
  output logic              wake_out
);
  localparam logic [3:0] REV_HI = 4'(REV_MAJOR);
  localparam logic [3:0] REV_LO = 4'(REV_MINOR);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [N_PINS-1:0] din_sync;
  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .din(pin_in), .dout(din_sync)
  );

  upd_op_e op_dout, op_irqen, op_wake, op_dir, op_low, op_high, op_rise, op_fall;
  always_comb begin
    op_dout  = pick_op(bus_we, bus_addr, 1'b1, A_DOUT,  A_DOUT_SET,  A_DOUT_CLR);
    op_irqen = pick_op(bus_we, bus_addr, 1'b1, A_IRQEN, A_IRQEN_SET, A_IRQEN_CLR);
    op_wake  = pick_op(bus_we, bus_addr, 1'b0, A_REV,   A_WAKE_SET,  A_WAKE_CLR);
    op_dir   = (bus_we && bus_addr == A_DIR)     ? OP_WRITE : OP_NONE;
    op_low   = (bus_we && bus_addr == A_LOWDET)  ? OP_WRITE : OP_NONE;
    op_high  = (bus_we && bus_addr == A_HIGHDET) ? OP_WRITE : OP_NONE;
    op_rise  = (bus_we && bus_addr == A_RISEDET) ? OP_WRITE : OP_NONE;
    op_fall  = (bus_we && bus_addr == A_FALLDET) ? OP_WRITE : OP_NONE;
  end

  logic [N_PINS-1:0] dout_q, irqen_q, wake_en_q, dir_q, low_q, high_q, rise_q, fall_q;

  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_dout  (.clk(clk), .rst_n(rst_q), .op(op_dout),  .wdata(bus_wdata), .q(dout_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_irqen (.clk(clk), .rst_n(rst_q), .op(op_irqen), .wdata(bus_wdata), .q(irqen_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_wake  (.clk(clk), .rst_n(rst_q), .op(op_wake),  .wdata(bus_wdata), .q(wake_en_q));
  gpio_alias_reg #(.W(N_PINS), .RST('1)) u_dir   (.clk(clk), .rst_n(rst_q), .op(op_dir),   .wdata(bus_wdata), .q(dir_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_low   (.clk(clk), .rst_n(rst_q), .op(op_low),   .wdata(bus_wdata), .q(low_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_high  (.clk(clk), .rst_n(rst_q), .op(op_high),  .wdata(bus_wdata), .q(high_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_rise  (.clk(clk), .rst_n(rst_q), .op(op_rise),  .wdata(bus_wdata), .q(rise_q));
  gpio_alias_reg #(.W(N_PINS), .RST('0)) u_fall  (.clk(clk), .rst_n(rst_q), .op(op_fall),  .wdata(bus_wdata), .q(fall_q));

  // Configuration and control registers.
  logic              syscfg_wake_q, syscfg_wake_d, syscfg_en;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  always_comb begin
    syscfg_en     = bus_we && bus_addr == A_SYSCFG;
    syscfg_wake_d = bus_wdata[WAKE_GLB_BIT];
    ctrl_en       = bus_we && bus_addr == A_CTRL;
    ctrl_d        = bus_wdata[CTRL_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      syscfg_wake_q <= 1'b0;
      ctrl_q        <= '0;
    end else begin
      if (syscfg_en) syscfg_wake_q <= syscfg_wake_d;
      if (ctrl_en)   ctrl_q        <= ctrl_d;
    end
  end

  logic [N_PINS-1:0] status_q;
  logic              stat_clr_we;
  assign stat_clr_we = bus_we && bus_addr == A_STATUS;

  gpio_event #(.W(N_PINS)) u_event (
    .clk(clk), .rst_n(rst_q), .lvl(din_sync),
    .low_en(low_q), .high_en(high_q), .rise_en(rise_q), .fall_en(fall_q),
    .clr_we(stat_clr_we), .clr_mask(bus_wdata), .status(status_q)
  );

  // Registered request outputs.
  logic irq_d, wake_d, irq_q, wake_q;
  always_comb begin
    irq_d  = |(status_q & irqen_q);
    wake_d = syscfg_wake_q & (|(status_q & wake_en_q));
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

  assign irq_out   = irq_q;
  assign wake_out  = wake_q;
  assign pin_out   = dout_q;
  assign pin_drive = ~dir_q;

  // Read multiplexer, same-cycle.
  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      A_REV:       bus_rdata[7:0] = {REV_HI, REV_LO};
      A_SYSCFG:    bus_rdata[WAKE_GLB_BIT] = syscfg_wake_q;
      A_SYSSTAT:   bus_rdata[0] = rst_q;
      A_STATUS:    bus_rdata = status_q;
      A_IRQEN, A_IRQEN_CLR, A_IRQEN_SET: bus_rdata = irqen_q;
      A_CTRL:      bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_DIR:       bus_rdata = dir_q;
      A_DIN:       bus_rdata = din_sync;
      A_DOUT, A_DOUT_CLR, A_DOUT_SET:    bus_rdata = dout_q;
      A_LOWDET:    bus_rdata = low_q;
      A_HIGHDET:   bus_rdata = high_q;
      A_RISEDET:   bus_rdata = rise_q;
      A_FALLDET:   bus_rdata = fall_q;
      A_WAKE_CLR, A_WAKE_SET:            bus_rdata = wake_en_q;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic [7:0]        bus_addr,
  input logic              bus_we,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] pin_out,
  input logic              irq_out,
  input logic              wake_out,
  input logic [N_PINS-1:0] status,
  input logic [N_PINS-1:0] irqen,
  input logic              syscfg_wake,
  input logic [N_PINS-1:0] low_en,
  input logic [N_PINS-1:0] high_en,
  input logic [N_PINS-1:0] rise_en,
  input logic [N_PINS-1:0] fall_en
);
  // R4
  dout_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_DOUT_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  irqen_clr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_IRQEN_CLR) |=> ((irqen & $past(bus_wdata)) == '0));

  // R9
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|($past(status) & ~status)) |-> $past(bus_we && bus_addr == A_STATUS));

  // R12
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (|(status & ~$past(status))) |-> $past(|(low_en | high_en | rise_en | fall_en)));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_out |-> $past(|(status & irqen)));

  // R11
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wake_out |-> $past(syscfg_wake));
endmodule

bind gpio_bank_irq gpio_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_q(rst_q), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .irq_out(irq_out), .wake_out(wake_out),
  .status(status_q), .irqen(irqen_q), .syscfg_wake(syscfg_wake_q),
  .low_en(low_q), .high_en(high_q), .rise_en(rise_q), .fall_en(fall_q)
);

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/100ps
module sim_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_drive;
  logic        irq_out, wake_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_drive(pin_drive), .irq_out(irq_out), .wake_out(wake_out)
  );

  // Vector: {rd, addr[7:0], data[31:0], req[3:0]}; rd=1 checks read data.
  localparam int NV = 24;
  localparam logic [44:0] VECS [NV] = '{
    {1'b1, 8'h00, 32'h0000_0025, 4'd2},   // R2 revision
    {1'b1, 8'h14, 32'h0000_0001, 4'd2},   // R2 reset done
    {1'b0, 8'h30, 32'h0000_0003, 4'd2},
    {1'b1, 8'h30, 32'h0000_0003, 4'd2},   // R2 control
    {1'b1, 8'h34, 32'hFFFF_FFFF, 4'd1},   // R1 direction
    {1'b1, 8'h1C, 32'h0000_0000, 4'd1},   // R1 enable
    {1'b1, 8'h18, 32'h0000_0000, 4'd1},   // R1 status
    {1'b1, 8'h3C, 32'h0000_0000, 4'd1},   // R1 data-out
    {1'b0, 8'h3C, 32'h0000_00F0, 4'd4},
    {1'b0, 8'h94, 32'h0000_0003, 4'd4},
    {1'b1, 8'h3C, 32'h0000_00F3, 4'd4},   // R4 set alias
    {1'b0, 8'h90, 32'h0000_0030, 4'd4},
    {1'b1, 8'h3C, 32'h0000_00C3, 4'd4},   // R4 clear alias
    {1'b0, 8'h64, 32'h0000_00A0, 4'd5},
    {1'b1, 8'h1C, 32'h0000_00A0, 4'd5},   // R5 set alias
    {1'b0, 8'h60, 32'h0000_0020, 4'd5},
    {1'b1, 8'h1C, 32'h0000_0080, 4'd5},   // R5 clear alias
    {1'b0, 8'h1C, 32'h0000_0001, 4'd5},
    {1'b1, 8'h64, 32'h0000_0001, 4'd5},   // R5 alias read
    {1'b0, 8'h84, 32'h0000_0005, 4'd11},
    {1'b0, 8'h80, 32'h0000_0001, 4'd11},
    {1'b1, 8'h84, 32'h0000_0004, 4'd11},  // R11 wake enable
    {1'b1, 8'h10, 32'h0000_0000, 4'd11},  // R11 switch off
    {1'b1, 8'h38, 32'h0000_0000, 4'd6}    // R6 idle pins
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(4);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      logic [31:0] r;
      v = VECS[i];
      if (v[44]) begin
        bus_rd(v[43:36], r);
        checks++;
        if (r !== v[35:4]) begin
          failures++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", v[3:0], i, r, v[35:4]);
        end
      end else begin
        bus_wr(v[43:36], v[35:4]);
      end
    end

    // R3 direction and drive
    bus_wr(8'h34, 32'hFFFF_FF00);
    check("R3 pin_drive", pin_drive, 32'h0000_00FF);
    check("R3 pin_out", pin_out, 32'h0000_00C3);

    // R6 two-flop visibility
    pin_in = 32'h1234_5678;
    tick(1);
    rd_check("R6 after one edge", 8'h38, 32'h0);
    tick(1);
    rd_check("R6 after two edges", 8'h38, 32'h1234_5678);

    // R12 no detect enables
    tick(3);
    rd_check("R12 status after toggle", 8'h18, 32'h0);
    pin_in = 32'h0;
    tick(4);
    rd_check("R12 status after return", 8'h18, 32'h0);

    // R7 and R10 edge detection and interrupt timing
    bus_wr(8'h48, 32'h1);
    bus_wr(8'h4C, 32'h2);
    pin_in = 32'h1;
    tick(3);
    rd_check("R7 rise status", 8'h18, 32'h1);
    check("R10 irq not yet", {31'b0, irq_out}, 32'h0);
    tick(1);
    check("R10 irq raised", {31'b0, irq_out}, 32'h1);

    // R9 write zero then one
    bus_wr(8'h18, 32'h0);
    rd_check("R9 zero write", 8'h18, 32'h1);
    bus_wr(8'h18, 32'h1);
    rd_check("R9 one write", 8'h18, 32'h0);
    check("R10 irq lags clear", {31'b0, irq_out}, 32'h1);
    tick(1);
    check("R10 irq dropped", {31'b0, irq_out}, 32'h0);
    tick(3);
    rd_check("R7 held level no event", 8'h18, 32'h0);

    pin_in = 32'h3;
    tick(4);
    rd_check("R7 rise on fall-only pin", 8'h18, 32'h0);
    pin_in = 32'h1;
    tick(3);
    rd_check("R7 fall status", 8'h18, 32'h2);
    tick(2);
    check("R10 masked bit", {31'b0, irq_out}, 32'h0);
    bus_wr(8'h18, 32'hFFFF_FFFF);

    // R8 level detection with set priority
    bus_wr(8'h44, 32'h10);
    rd_check("R8 high not met", 8'h18, 32'h0);
    pin_in = 32'h11;
    tick(3);
    rd_check("R8 high status", 8'h18, 32'h10);
    bus_wr(8'h18, 32'h10);
    rd_check("R8 re-set while held", 8'h18, 32'h10);
    pin_in = 32'h01;
    tick(3);
    bus_wr(8'h18, 32'h10);
    rd_check("R8 clear after release", 8'h18, 32'h0);
    bus_wr(8'h40, 32'h20);
    rd_check("R8 low one edge later", 8'h18, 32'h0);
    tick(1);
    rd_check("R8 low status", 8'h18, 32'h20);
    bus_wr(8'h40, 32'h0);
    bus_wr(8'h18, 32'h20);
    rd_check("R8 low cleared", 8'h18, 32'h0);

    // R11 wake gating
    bus_wr(8'h48, 32'h5);
    pin_in = 32'h05;
    tick(3);
    rd_check("R11 wake source status", 8'h18, 32'h4);
    tick(2);
    check("R11 wake gated", {31'b0, wake_out}, 32'h0);
    bus_wr(8'h10, 32'h4);
    check("R11 wake lags switch", {31'b0, wake_out}, 32'h0);
    tick(1);
    check("R11 wake raised", {31'b0, wake_out}, 32'h1);
    check("R10 irq ignores wake source", {31'b0, irq_out}, 32'h0);
    bus_wr(8'h80, 32'h4);
    tick(1);
    check("R11 wake after clear alias", {31'b0, wake_out}, 32'h0);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
    check("R1 wake in reset", {31'b0, wake_out}, 32'h0);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 pin_drive in reset", pin_drive, 32'h0);
    rd_check("R1 enable in reset", 8'h1C, 32'h0);
    rd_check("R1 status in reset", 8'h18, 32'h0);
    rd_check("R1 wake enable in reset", 8'h84, 32'h0);
    rd_check("R1 rise enable in reset", 8'h48, 32'h0);
    tick(1);
    rst_n = 1'b1;
    tick(4);
    rd_check("R1 status after reset", 8'h18, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule